// File: doc/BRIEF.md
# Line Sensor Readout Timing Generator

This block sits on the host side of a 256-pixel linear light sensor and generates all of the sensor's digital control lines from a single system clock. It divides the system clock down to a free-running sensor clock, places the start-of-readout pulse with margin around exactly one sensor clock rising edge, and drives the shutter line so that the light-collection window is shorter than the frame.

For each pixel that the sensor presents at its analog output, the block raises a one-cycle conversion strobe for an external ADC. The strobe comes a programmable number of system clocks after the sensor clock rising edge, so the analog output has time to settle. The strobe is accompanied by the pixel index and, for the final pixel, an end-of-frame flag. Frame requests may arrive at any time. A request made during a readout is held until that readout finishes, so a running frame is never cut short.

The three timing settings (half period, light window and strobe delay) are static while the block runs. Changing them is only allowed between frames.

Top module: `linescan_timing`

## Requirements
- R1: While reset is held, sclk, si, adc_stb and frame_end are 0, dis is 1 (light collection stopped) and pix_idx is 0.
- R2: sclk is a square wave in which each level lasts half_div+1 system clocks, so its period is 2*(half_div+1) system clocks.
- R3: si rises in the same cycle as an sclk falling edge and falls at the next sclk falling edge. It is therefore high for exactly one sclk rising edge, with half_div+1 system clocks of setup and half_div+1 of hold around it.
- R4: A frame produces exactly 256 adc_stb pulses, one for each sclk rising edge beginning with the edge that samples si. pix_idx reads 0, 1, …, 255 in that order on those pulses.
- R5: adc_stb is a single-cycle pulse that rises stb_dly+1 system clocks after sclk rises, provided stb_dly is at most 2*half_div.
- R6: frame_end is high only in the cycle of the adc_stb pulse for pix_idx 255, and once per frame.
- R7: dis falls in the same cycle that si rises. It rises together with sclk rising edge number 3+int_len of the frame, where the si-sampling edge is number 1. It is therefore low for (half_div+1)*(5+2*int_len) system clocks.
- R8: When the light window is longer than the frame, dis stays low after frame_end until its count expires.
- R9: A frame_req pulse made while a frame is running produces no si until that frame's last strobe. It then starts exactly one further frame, and several such pulses during one frame merge into one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| half_div | input | DIV_W | Sensor clock half period minus one, in system clocks |
| int_len | input | INT_W | Light window length in sensor clock periods |
| stb_dly | input | DLY_W | Strobe delay after sclk rises, minus one, in system clocks |
| frame_req | input | 1 | Request to read one frame |
| sclk | output | 1 | Sensor clock |
| si | output | 1 | Start-of-readout pulse to the sensor |
| dis | output | 1 | Shutter; high stops light collection |
| adc_stb | output | 1 | One-cycle ADC conversion strobe |
| pix_idx | output | IDX_W | Index of the pixel being converted |
| frame_end | output | 1 | Marks the strobe of the last pixel |

## Verification
The assertions assume that the settings stay fixed while a frame runs and that stb_dly fits inside one sensor clock period. Under those conditions each strobe is followed by a cycle without a strobe, and the shutter edges coincide with sclk or si edges. The stimulus changes half_div, int_len and stb_dly only while the block is idle between frames. Every strobe delay it uses is at most 2*half_div. The long-window case is run with the shortest sensor clock so that it stays within the run time.

// File: rtl/linescan_timing.sv
module linescan_timing #(
  parameter int NPIX  = 256,
  parameter int DIV_W = 8,
  parameter int INT_W = 12,
  parameter int DLY_W = 8,
  localparam int IDX_W = $clog2(NPIX)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] half_div,
  input  logic [INT_W-1:0] int_len,
  input  logic [DLY_W-1:0] stb_dly,
  input  logic             frame_req,
  output logic             sclk,
  output logic             si,
  output logic             dis,
  output logic             adc_stb,
  output logic [IDX_W-1:0] pix_idx,
  output logic             frame_end
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NPIX - 1);

  logic [DIV_W-1:0] div_cnt;
  logic [DLY_W-1:0] dcnt;
  logic [INT_W-1:0] icnt;
  logic req_q, active, pend, irun;

  wire tick      = div_cnt >= half_div;
  wire rise_ev   = tick & ~sclk;
  wire fall_ev   = tick & sclk;
  wire last      = pix_idx == LAST;
  wire launch    = fall_ev & ~si & req_q & ~active;
  wire capture   = rise_ev & (si | (active & ~last));
  wire fire      = pend & (dcnt == stb_dly);
  wire int_start = rise_ev & active & ~si & (pix_idx == IDX_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_cnt <= '0;
      sclk    <= 1'b0;
      si      <= 1'b0;
      req_q   <= 1'b0;
    end else begin
      div_cnt <= tick ? '0 : div_cnt + 1'b1;
      sclk    <= sclk ^ tick;
      if (fall_ev) si <= launch;
      req_q   <= frame_req | (req_q & ~launch);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active    <= 1'b0;
      pix_idx   <= '0;
      pend      <= 1'b0;
      dcnt      <= '0;
      adc_stb   <= 1'b0;
      frame_end <= 1'b0;
    end else begin
      if (rise_ev & si)       active <= 1'b1;
      else if (fire & last)   active <= 1'b0;
      if (rise_ev & si)       pix_idx <= '0;
      else if (capture)       pix_idx <= pix_idx + 1'b1;
      if (capture) begin
        pend <= 1'b1;
        dcnt <= '0;
      end else if (fire) begin
        pend <= 1'b0;
      end else if (pend) begin
        dcnt <= dcnt + 1'b1;
      end
      adc_stb   <= fire;
      frame_end <= fire & last & active;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dis  <= 1'b1;
      irun <= 1'b0;
      icnt <= '0;
    end else if (launch) begin
      dis  <= 1'b0;
      irun <= 1'b0;
    end else if (int_start) begin
      icnt <= int_len;
      if (int_len == '0) dis  <= 1'b1;
      else               irun <= 1'b1;
    end else if (rise_ev & irun) begin
      icnt <= icnt - 1'b1;
      if (icnt == INT_W'(1)) begin
        dis  <= 1'b1;
        irun <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/linescan_timing_chk.sv
module linescan_timing_chk #(
  parameter int NPIX  = 256,
  parameter int IDX_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sclk,
  input logic             si,
  input logic             dis,
  input logic             adc_stb,
  input logic [IDX_W-1:0] pix_idx,
  input logic             frame_end
);
  assert_si_on_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(si) || $fell(si)) |-> $fell(sclk));

  assert_stb_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    adc_stb |=> !adc_stb);

  assert_end_on_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |-> (adc_stb && pix_idx == IDX_W'(NPIX - 1)));

  assert_dis_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dis) |-> $rose(sclk));

  assert_dis_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dis) |-> $rose(si));
endmodule

bind linescan_timing linescan_timing_chk #(.NPIX(NPIX), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sclk(sclk), .si(si), .dis(dis),
  .adc_stb(adc_stb), .pix_idx(pix_idx), .frame_end(frame_end));

// File: tb/test_linescan_timing.sv
`timescale 1ns/1ps
module test_linescan_timing;
  logic clk = 1'b0, rst_n = 1'b0, frame_req = 1'b0;
  logic [7:0] half_div = 8'd0, stb_dly = 8'd0;
  logic [11:0] int_len = 12'd0;
  logic sclk, si, dis, adc_stb, frame_end;
  logic [7:0] pix_idx;

  int tests = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  linescan_timing i_linescan_timing (
    .clk(clk), .rst_n(rst_n), .half_div(half_div), .int_len(int_len),
    .stb_dly(stb_dly), .frame_req(frame_req), .sclk(sclk), .si(si), .dis(dis),
    .adc_stb(adc_stb), .pix_idx(pix_idx), .frame_end(frame_end));

  // {half_div, int_len, stb_dly}
  localparam logic [27:0] VEC [0:3] = '{
    {8'd0, 12'd5,   8'd0},
    {8'd1, 12'd0,   8'd2},
    {8'd3, 12'd100, 8'd5},
    {8'd2, 12'd253, 8'd3}
  };

  // monitor, sampled on the falling clock edge
  logic p_sclk = 0, p_si = 0;
  int since_rise = 0, per = 0, setup = 0, hold = 0, stb_cnt = 0, exp_idx = 0;
  int idx_err = 0, dly_err = 0, fe_cnt = 0, fe_err = 0, dis_low = 0, si_rises = 0;
  bit dis_done = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (si && !p_si) begin
        si_rises++;
        setup = 0; hold = 0; stb_cnt = 0; exp_idx = 0; idx_err = 0; dly_err = 0;
        fe_cnt = 0; fe_err = 0; dis_low = 0; dis_done = 0;
      end
      if (sclk && !p_sclk) begin
        per = since_rise + 1;
        since_rise = 0;
      end else since_rise++;
      if (si && !sclk) setup++;
      if (si && sclk) hold++;
      if (!dis && !dis_done) dis_low++;
      if (dis && si_rises > 0) dis_done = 1;
      if (adc_stb) begin
        stb_cnt++;
        if (pix_idx != 8'(exp_idx)) idx_err++;
        exp_idx++;
        if (since_rise != int'(stb_dly) + 1) dly_err++;
      end
      if (frame_end) begin
        fe_cnt++;
        if (!(adc_stb && pix_idx == 8'd255)) fe_err++;
      end
    end
    p_sclk = sclk;
    p_si = si;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_req();
    @(negedge clk) frame_req = 1'b1;
    @(negedge clk) frame_req = 1'b0;
  endtask

  task automatic wait_end();
    for (int k = 0; k < 20000; k++) begin
      @(negedge clk);
      if (frame_end) break;
    end
    @(negedge clk);
  endtask

  task automatic wait_dis();
    for (int k = 0; k < 20000; k++) begin
      if (dis) break;
      @(negedge clk);
    end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    repeat (4) @(negedge clk);
    check(sclk == 0 && si == 0 && adc_stb == 0 && frame_end == 0, "R1 outputs low",
          {sclk, si, adc_stb, frame_end}, 0);
    check(dis == 1 && pix_idx == 0, "R1 dis high, index zero", {dis, pix_idx}, 9'h100);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);

    // table walk: R2 R3 R4 R5 R6 R7
    for (int v = 0; v < 4; v++) begin
      int h, l;
      half_div = VEC[v][27:20];
      int_len  = VEC[v][19:8];
      stb_dly  = VEC[v][7:0];
      h = int'(half_div) + 1;
      l = int'(int_len);
      repeat (20) @(negedge clk);
      pulse_req();
      wait_end();
      check(per == 2 * h, "R2 sclk period", per, 2 * h);
      check(setup == h, "R3 si setup", setup, h);
      check(hold == h, "R3 si hold", hold, h);
      check(stb_cnt == 256, "R4 strobes per frame", stb_cnt, 256);
      check(idx_err == 0, "R4 index order", idx_err, 0);
      check(dly_err == 0, "R5 strobe delay", dly_err, 0);
      check(fe_cnt == 1 && fe_err == 0, "R6 frame end", fe_cnt * 10 + fe_err, 10);
      wait_dis();
      check(dis_low == h * (5 + 2 * l), "R7 dis window", dis_low, h * (5 + 2 * l));
    end

    // R9 queued requests, merged, no abort
    half_div = 8'd1; int_len = 12'd4; stb_dly = 8'd1;
    repeat (20) @(negedge clk);
    si_rises = 0;
    pulse_req();
    repeat (300) @(negedge clk);
    pulse_req();
    repeat (50) @(negedge clk);
    pulse_req();
    wait_end();
    check(si_rises == 1, "R9 no si during frame", si_rises, 1);
    check(stb_cnt == 256, "R9 first frame completes", stb_cnt, 256);
    wait_end();
    check(si_rises == 2 && stb_cnt == 256, "R9 queued frame runs", si_rises, 2);
    repeat (3000) @(negedge clk);
    check(si_rises == 2, "R9 merged requests", si_rises, 2);

    // R8 window longer than frame
    half_div = 8'd0; int_len = 12'd1000; stb_dly = 8'd0;
    repeat (20) @(negedge clk);
    pulse_req();
    wait_end();
    check(dis == 0, "R8 dis low at frame end", dis, 0);
    repeat (600) @(negedge clk);
    check(dis == 0, "R8 dis still low", dis, 0);
    wait_dis();
    check(dis_low == 5 + 2 * 1000, "R8 long window", dis_low, 2005);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule